// File: doc/BRIEF.md
# NAND ECC-Interleaved Page Reader

This block reads one NAND flash page as a series of ECC steps. It hands each flash command to an external command sequencer through a start/done handshake. It then reads the data with its own read-enable strobe. A page read first opens the page at column 0. Each step then does the following: it arms the external ECC engine, moves the read column to that step's data chunk and streams the chunk out on a valid/ready interface. It then moves the column to that step's ECC bytes in the spare area and captures those bytes into an internal buffer. Once the last step's ECC bytes are captured, the ECC engine's consumer can correct each step against the stored codes.

A second mode checks a block's factory bad-block marker. It opens page 0 of the block at the spare-area marker column, reads one bus word and reports whether that word is erased. All column positions and sizes are counted in bus words of `DQ_W` bits, so the same logic serves an 8-bit or a 16-bit bus.

The controller is a state machine with nine states. The transitions are:
- IDLE goes to PG_CMD on `go` with `mode_bbm` low, or to BB_CMD on `go` with `mode_bbm` high.
- PG_CMD goes to ARM when the sequencer acknowledges.
- ARM goes to DCOL after one cycle.
- DCOL goes to DREAD when the sequencer acknowledges.
- DREAD goes to SCOL when the chunk's last word is read.
- SCOL goes to EREAD when the sequencer acknowledges.
- EREAD goes to ARM when the step's last ECC word is read and more steps remain, and to IDLE after the final step.
- BB_CMD goes to BB_READ when the sequencer acknowledges.
- BB_READ goes to IDLE when the marker word is read.

Top module: `nand_ecc_page_reader`

## Requirements
- R1: Reset state: while reset is held, `busy`, `seq_start`, `ecc_arm`, `dout_valid` and `bb_done` are 0 and `nand_re_n` is 1.
- R2: A page read issues its first command with `seq_op`=0 (full page read), `seq_col`=0 and `seq_row`={`blk_addr`,`pg_addr`}.
- R3: Each step s (0..STEPS-1) runs in this order:
  - one `ecc_arm` pulse;
  - a command with `seq_op`=1 (column move) to column s*CHUNK;
  - CHUNK data words;
  - a column move to PAGE_WORDS+ECC_POS0+s*EBYTES;
  - EBYTES ECC words.
- R4: Every data word is presented on `dout_data` with `dout_step`=s. `dout_last` is 1 only on the CHUNK-th word of a step. While `dout_valid` is high and `dout_ready` is low, the data and flags hold steady.
- R5: Each word read drives `nand_re_n` low for exactly RE_LOW clock cycles. `nand_dq` is sampled at the clock edge that returns `nand_re_n` high.
- R6: Under any `dout_ready` pattern, every data word of the page reaches the stream exactly once and in column order. No data strobe starts while an unaccepted word is held.
- R7: ECC word k of step s is stored at index i=s*EBYTES+k. It appears on `ecc_codes[i*DQ_W +: DQ_W]` and stays there until it is overwritten.
- R8: `busy` rises in the cycle after `go` is accepted in IDLE. It falls in the cycle after the final ECC word is captured, after exactly STEPS*(CHUNK+EBYTES) strobes. A `go` while `busy` is high has no effect.
- R9: Bad-block mode issues one full page read with row {`blk_addr`,0} and column PAGE_WORDS+MARK_POS, then reads one word. It pulses `bb_done` for one cycle and sets `bb_bad`=1 if any bit of that word is 0 (1 only when the word is all ones is good). It neither arms the ECC engine nor streams data.
- R10: `seq_start` is a one-cycle pulse per command. No new command starts before `seq_done` answers the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start request, taken only when idle |
| mode_bbm | input | 1 | 1 = bad-block marker check, 0 = page read |
| blk_addr | input | BLK_W | Block number |
| pg_addr | input | PG_W | Page within block |
| seq_start | output | 1 | Command request pulse to the sequencer |
| seq_op | output | 1 | 0 = full page read, 1 = column move |
| seq_col | output | COL_W | Column in bus words |
| seq_row | output | ROW_W | Row (block and page) |
| seq_done | input | 1 | Sequencer completion pulse |
| nand_re_n | output | 1 | Read enable strobe, active low |
| nand_dq | input | DQ_W | Flash data bus |
| ecc_arm | output | 1 | Per-step ECC engine start pulse |
| ecc_codes | output | ECC_TOTAL*DQ_W | Captured stored ECC words |
| dout_valid | output | 1 | Stream word valid |
| dout_ready | input | 1 | Stream word accepted |
| dout_data | output | DQ_W | Stream data word |
| dout_step | output | STEP_W | ECC step of the word |
| dout_last | output | 1 | Last word of the step |
| busy | output | 1 | Operation in progress |
| bb_done | output | 1 | Marker check finished pulse |
| bb_bad | output | 1 | Marker check verdict |

## Verification
The assertions rely on three properties of the inputs. The sequencer raises `seq_done` once per command, and only after it has seen `seq_start`. `nand_dq` is stable at the edge that ends each low phase of `nand_re_n`. The stream sink may stall for any length of time. The bench models the sequencer so that it answers each command exactly once after a fixed delay. Its flash model advances its column only on each rising `nand_re_n` and holds the bus constant in between. Its stream sink runs always-ready, a periodic stall pattern and long stalls, which covers backpressure without breaking the handshake rules.

// File: rtl/nrd_pkg.sv
package nrd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PG_CMD,
        ST_ARM,
        ST_DCOL,
        ST_DREAD,
        ST_SCOL,
        ST_EREAD,
        ST_BB_CMD,
        ST_BB_READ
    } rdr_state_e;

    localparam logic OP_PAGE_READ = 1'b0;
    localparam logic OP_COL_MOVE  = 1'b1;

endpackage

// File: rtl/nrd_strobe.sv
module nrd_strobe #(
    parameter int DQ_W   = 8,
    parameter int RE_LOW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  logic [DQ_W-1:0] dq,
    output logic            re_n,
    output logic            busy,
    output logic            got,
    output logic [DQ_W-1:0] word
);
    localparam int CNT_W = $clog2(RE_LOW + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RE_LOW - 1);

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            got      <= 1'b0;
            word     <= '0;
        end else begin
            got <= 1'b0;
            if (active_q) begin
                if (cnt_q == CNT_LAST) begin
                    active_q <= 1'b0;
                    cnt_q    <= '0;
                    got      <= 1'b1;
                    word     <= dq;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (fire) begin
                active_q <= 1'b1;
                cnt_q    <= '0;
            end
        end
    end

    assign re_n = ~active_q;
    assign busy = active_q;

    // Independent low-phase length counter for the width check
    logic [CNT_W-1:0] low_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) low_run_q <= '0;
        else if (re_n) low_run_q <= '0;
        else if (low_run_q != CNT_W'(RE_LOW)) low_run_q <= low_run_q + 1'b1;
    end

    AST_RE_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(re_n) |-> low_run_q >= CNT_W'(RE_LOW)); // R5
    AST_NO_FIRE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> re_n); // R5

endmodule

// File: rtl/nrd_ecc_store.sv
module nrd_ecc_store #(
    parameter int DQ_W  = 8,
    parameter int TOTAL = 12,
    parameter int IDX_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [IDX_W-1:0]      idx,
    input  logic [DQ_W-1:0]       wdata,
    output logic [TOTAL*DQ_W-1:0] codes
);
    generate
        for (genvar i = 0; i < TOTAL; i++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) codes[i*DQ_W +: DQ_W] <= '0;
                else if (we && idx == IDX_W'(i)) codes[i*DQ_W +: DQ_W] <= wdata;
            end
        end
    endgenerate

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> idx < IDX_W'(TOTAL)); // R7

endmodule

// File: rtl/nand_ecc_page_reader.sv
module nand_ecc_page_reader
    import nrd_pkg::*;
#(
    parameter int PAGE_WORDS = 2048,
    parameter int CHUNK      = 512,
    parameter int EBYTES     = 3,
    parameter int ECC_POS0   = 40,
    parameter int MARK_POS   = 0,
    parameter int RE_LOW     = 3,
    parameter int DQ_W       = 8,
    parameter int BLK_W      = 10,
    parameter int PG_W       = 6,
    parameter int COL_W      = 12,
    localparam int STEPS     = PAGE_WORDS / CHUNK,
    localparam int STEP_W    = (STEPS > 1) ? $clog2(STEPS) : 1,
    localparam int ECC_TOTAL = STEPS * EBYTES,
    localparam int ROW_W     = BLK_W + PG_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      go,
    input  logic                      mode_bbm,
    input  logic [BLK_W-1:0]          blk_addr,
    input  logic [PG_W-1:0]           pg_addr,
    output logic                      seq_start,
    output logic                      seq_op,
    output logic [COL_W-1:0]          seq_col,
    output logic [ROW_W-1:0]          seq_row,
    input  logic                      seq_done,
    output logic                      nand_re_n,
    input  logic [DQ_W-1:0]           nand_dq,
    output logic                      ecc_arm,
    output logic [ECC_TOTAL*DQ_W-1:0] ecc_codes,
    output logic                      dout_valid,
    input  logic                      dout_ready,
    output logic [DQ_W-1:0]           dout_data,
    output logic [STEP_W-1:0]         dout_step,
    output logic                      dout_last,
    output logic                      busy,
    output logic                      bb_done,
    output logic                      bb_bad
);
    localparam int CNT_W  = $clog2(((CHUNK > EBYTES) ? CHUNK : EBYTES) + 1);
    localparam int EIDX_W = $clog2(ECC_TOTAL + 1);
    localparam logic [CNT_W-1:0]  CHUNK_LAST = CNT_W'(CHUNK - 1);
    localparam logic [CNT_W-1:0]  EB_LAST    = CNT_W'(EBYTES - 1);
    localparam logic [STEP_W-1:0] STEP_LAST  = STEP_W'(STEPS - 1);
    localparam logic [COL_W-1:0]  SPARE_BASE = COL_W'(PAGE_WORDS + ECC_POS0);
    localparam logic [COL_W-1:0]  MARK_COL   = COL_W'(PAGE_WORDS + MARK_POS);

    rdr_state_e state_q, state_d;

    logic              cmd_sent_q;
    logic              cmd_state;
    logic              cmd_ack;
    logic              rd_fire;
    logic              rd_busy;
    logic              rd_got;
    logic [DQ_W-1:0]   rd_word;
    logic [ROW_W-1:0]  row_q;
    logic [STEP_W-1:0] step_q;
    logic [CNT_W-1:0]  wcnt_q;
    logic [EIDX_W-1:0] eidx_q;
    logic [COL_W-1:0]  data_pos_q;
    logic [COL_W-1:0]  spare_pos_q;
    logic              hold_v_q;
    logic [DQ_W-1:0]   hold_d_q;
    logic [STEP_W-1:0] hold_s_q;
    logic              hold_l_q;
    logic              bb_done_q;
    logic              bb_bad_q;
    logic              ecc_we;

    assign cmd_ack = cmd_sent_q && seq_done;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (go) state_d = mode_bbm ? ST_BB_CMD : ST_PG_CMD;
            ST_PG_CMD:  if (cmd_ack) state_d = ST_ARM;
            ST_ARM:     state_d = ST_DCOL;
            ST_DCOL:    if (cmd_ack) state_d = ST_DREAD;
            ST_DREAD:   if (rd_got && wcnt_q == CHUNK_LAST) state_d = ST_SCOL;
            ST_SCOL:    if (cmd_ack) state_d = ST_EREAD;
            ST_EREAD:   if (rd_got && wcnt_q == EB_LAST)
                            state_d = (step_q == STEP_LAST) ? ST_IDLE : ST_ARM;
            ST_BB_CMD:  if (cmd_ack) state_d = ST_BB_READ;
            ST_BB_READ: if (rd_got) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        cmd_state = 1'b0;
        seq_op    = OP_PAGE_READ;
        seq_col   = '0;
        ecc_arm   = 1'b0;
        rd_fire   = 1'b0;
        unique case (state_q)
            ST_PG_CMD:  cmd_state = 1'b1;
            ST_ARM:     ecc_arm = 1'b1;
            ST_DCOL: begin
                cmd_state = 1'b1;
                seq_op    = OP_COL_MOVE;
                seq_col   = data_pos_q;
            end
            ST_DREAD:   rd_fire = !rd_busy && !rd_got && !hold_v_q;
            ST_SCOL: begin
                cmd_state = 1'b1;
                seq_op    = OP_COL_MOVE;
                seq_col   = spare_pos_q;
            end
            ST_EREAD:   rd_fire = !rd_busy && !rd_got;
            ST_BB_CMD: begin
                cmd_state = 1'b1;
                seq_col   = MARK_COL;
            end
            ST_BB_READ: rd_fire = !rd_busy && !rd_got;
            default: ;
        endcase
        seq_start = cmd_state && !cmd_sent_q;
    end

    assign seq_row = row_q;
    assign busy    = (state_q != ST_IDLE);
    assign ecc_we  = (state_q == ST_EREAD) && rd_got;

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_sent_q  <= 1'b0;
            row_q       <= '0;
            step_q      <= '0;
            wcnt_q      <= '0;
            eidx_q      <= '0;
            data_pos_q  <= '0;
            spare_pos_q <= '0;
            hold_v_q    <= 1'b0;
            hold_d_q    <= '0;
            hold_s_q    <= '0;
            hold_l_q    <= 1'b0;
            bb_done_q   <= 1'b0;
            bb_bad_q    <= 1'b0;
        end else begin
            bb_done_q <= 1'b0;
            if (seq_start)     cmd_sent_q <= 1'b1;
            else if (cmd_ack)  cmd_sent_q <= 1'b0;

            if (state_q == ST_IDLE && go) begin
                row_q       <= {blk_addr, (mode_bbm ? {PG_W{1'b0}} : pg_addr)};
                step_q      <= '0;
                wcnt_q      <= '0;
                eidx_q      <= '0;
                data_pos_q  <= '0;
                spare_pos_q <= SPARE_BASE;
            end

            if (dout_valid && dout_ready) hold_v_q <= 1'b0;

            if (state_q == ST_DREAD && rd_got) begin
                hold_v_q <= 1'b1;
                hold_d_q <= rd_word;
                hold_s_q <= step_q;
                hold_l_q <= (wcnt_q == CHUNK_LAST);
                wcnt_q   <= (wcnt_q == CHUNK_LAST) ? '0 : wcnt_q + 1'b1;
            end

            if (ecc_we) begin
                eidx_q <= eidx_q + 1'b1;
                if (wcnt_q == EB_LAST) begin
                    wcnt_q      <= '0;
                    step_q      <= step_q + 1'b1;
                    data_pos_q  <= data_pos_q + COL_W'(CHUNK);
                    spare_pos_q <= spare_pos_q + COL_W'(EBYTES);
                end else begin
                    wcnt_q <= wcnt_q + 1'b1;
                end
            end

            if (state_q == ST_BB_READ && rd_got) begin
                bb_done_q <= 1'b1;
                bb_bad_q  <= (rd_word != {DQ_W{1'b1}});
            end
        end
    end

    assign dout_valid = hold_v_q;
    assign dout_data  = hold_d_q;
    assign dout_step  = hold_s_q;
    assign dout_last  = hold_l_q;
    assign bb_done    = bb_done_q;
    assign bb_bad     = bb_bad_q;

    nrd_strobe #(.DQ_W(DQ_W), .RE_LOW(RE_LOW)) strobe_i (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (rd_fire),
        .dq    (nand_dq),
        .re_n  (nand_re_n),
        .busy  (rd_busy),
        .got   (rd_got),
        .word  (rd_word)
    );

    nrd_ecc_store #(.DQ_W(DQ_W), .TOTAL(ECC_TOTAL), .IDX_W(EIDX_W)) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ecc_we),
        .idx   (eidx_q),
        .wdata (rd_word),
        .codes (ecc_codes)
    );

    // Outstanding-command tracker, separate from the state machine
    logic ast_outst_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ast_outst_q <= 1'b0;
        else if (seq_start) ast_outst_q <= 1'b1;
        else if (seq_done)  ast_outst_q <= 1'b0;
    end

    AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> !ast_outst_q); // R10
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> !seq_start); // R10
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid && !dout_ready |=> dout_valid && $stable(dout_data) && $stable(dout_last)); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> nand_re_n && !ecc_arm); // R8
    AST_BB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bb_done |=> !bb_done); // R9

endmodule

// File: tb/nand_ecc_page_reader_tb.sv
module nand_ecc_page_reader_tb_top;
    localparam int PAGE_WORDS = 16;
    localparam int CHUNK      = 4;
    localparam int EBYTES     = 2;
    localparam int ECC_POS0   = 3;
    localparam int MARK_POS   = 0;
    localparam int RE_LOW     = 2;
    localparam int DQ_W       = 8;
    localparam int BLK_W      = 4;
    localparam int PG_W       = 3;
    localparam int COL_W      = 6;
    localparam int STEPS      = PAGE_WORDS / CHUNK;
    localparam int STEP_W     = 2;
    localparam int ETOT       = STEPS * EBYTES;
    localparam int ROW_W      = BLK_W + PG_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0;
    logic mode_bbm = 1'b0;
    logic [BLK_W-1:0] blk_addr = '0;
    logic [PG_W-1:0]  pg_addr = '0;
    logic seq_start, seq_op, seq_done, nand_re_n, ecc_arm;
    logic [COL_W-1:0] seq_col;
    logic [ROW_W-1:0] seq_row;
    logic [DQ_W-1:0]  nand_dq;
    logic [ETOT*DQ_W-1:0] ecc_codes;
    logic dout_valid, dout_ready, dout_last, busy, bb_done, bb_bad;
    logic [DQ_W-1:0]   dout_data;
    logic [STEP_W-1:0] dout_step;

    always #2.5 clk = ~clk;

    nand_ecc_page_reader #(
        .PAGE_WORDS(PAGE_WORDS), .CHUNK(CHUNK), .EBYTES(EBYTES), .ECC_POS0(ECC_POS0),
        .MARK_POS(MARK_POS), .RE_LOW(RE_LOW), .DQ_W(DQ_W), .BLK_W(BLK_W),
        .PG_W(PG_W), .COL_W(COL_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .go(go), .mode_bbm(mode_bbm), .blk_addr(blk_addr),
        .pg_addr(pg_addr), .seq_start(seq_start), .seq_op(seq_op), .seq_col(seq_col),
        .seq_row(seq_row), .seq_done(seq_done), .nand_re_n(nand_re_n), .nand_dq(nand_dq),
        .ecc_arm(ecc_arm), .ecc_codes(ecc_codes), .dout_valid(dout_valid),
        .dout_ready(dout_ready), .dout_data(dout_data), .dout_step(dout_step),
        .dout_last(dout_last), .busy(busy), .bb_done(bb_done), .bb_bad(bb_bad)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Flash content model
    function automatic logic [7:0] flash(input int row, input int col);
        int b;
        b = row >> PG_W;
        if (col == PAGE_WORDS + MARK_POS)
            return (b == 5) ? 8'hFE : (b == 6) ? 8'h7F : 8'hFF;
        return 8'((row * 13) + (col * 7) + 5);
    endfunction

    int cur_row = 0;
    int col_ptr = 0;
    assign nand_dq = flash(cur_row, col_ptr);

    initial forever begin
        @(posedge nand_re_n);
        col_ptr = col_ptr + 1;
    end

    // Expected command and stream queues (scoreboard)
    int exp_op[$];
    int exp_col[$];
    int exp_row[$];
    int exp_data[$];
    int exp_step[$];
    int exp_last[$];
    int arm_cnt = 0;
    int strobe_cnt = 0;

    // Sequencer model and command monitor
    initial begin
        seq_done = 1'b0;
        @(negedge clk);
        forever begin
            if (seq_start) begin
                if (exp_op.size() == 0) begin
                    chk(0, "R10", "unexpected command col", int'(seq_col), -1);
                end else begin
                    int eo, ec, er;
                    eo = exp_op.pop_front();
                    ec = exp_col.pop_front();
                    er = exp_row.pop_front();
                    chk(int'(seq_op) == eo, (eo == 0) ? "R2" : "R3", "command op", int'(seq_op), eo);
                    chk(int'(seq_col) == ec, (eo == 0) ? "R2" : "R3", "command column", int'(seq_col), ec);
                    if (eo == 0) chk(int'(seq_row) == er, "R2", "command row", int'(seq_row), er);
                    if (eo == 1 && ec < PAGE_WORDS)
                        chk(arm_cnt == ec / CHUNK + 1, "R3", "arm pulses before data move", arm_cnt, ec / CHUNK + 1);
                end
                cur_row = int'(seq_row);
                col_ptr = int'(seq_col);
                repeat (2) @(negedge clk);
                chk(!seq_start, "R10", "start held while pending", int'(seq_start), 0);
                seq_done = 1'b1;
                @(negedge clk);
                seq_done = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    end

    // Sink ready pattern
    int rdy_mode = 0;
    int cyc = 0;
    initial begin
        dout_ready = 1'b1;
        forever begin
            @(negedge clk);
            cyc++;
            case (rdy_mode)
                0: dout_ready = 1'b1;
                1: dout_ready = (cyc % 4) != 0;
                default: dout_ready = (cyc % 40) < 4;
            endcase
        end
    end

    // Stream monitor, arm counter, strobe width monitor
    int low_run = 0;
    initial forever begin
        @(negedge clk);
        if (!rst_n) continue;
        if (ecc_arm) arm_cnt++;
        if (!nand_re_n) low_run++;
        else if (low_run > 0) begin
            chk(low_run == RE_LOW, "R5", "read enable low cycles", low_run, RE_LOW);
            strobe_cnt++;
            low_run = 0;
        end
        if (dout_valid && dout_ready) begin
            if (exp_data.size() == 0) begin
                chk(0, "R6", "unexpected stream word", int'(dout_data), -1);
            end else begin
                int ed, es, el;
                ed = exp_data.pop_front();
                es = exp_step.pop_front();
                el = exp_last.pop_front();
                chk(int'(dout_data) == ed, "R6", "stream data", int'(dout_data), ed);
                chk(int'(dout_step) == es, "R4", "stream step", int'(dout_step), es);
                chk(int'(dout_last) == el, "R4", "stream last flag", int'(dout_last), el);
            end
        end
    end

    task automatic pulse_go(input bit bbm, input int blk, input int pg);
        go = 1'b1; mode_bbm = bbm; blk_addr = BLK_W'(blk); pg_addr = PG_W'(pg);
        @(negedge clk);
        go = 1'b0; mode_bbm = 1'b0;
    endtask

    task automatic run_page(input int blk, input int pg, input int rmode, input bit poke);
        int row;
        row = (blk << PG_W) | pg;
        rdy_mode = rmode;
        arm_cnt = 0;
        exp_op.push_back(0); exp_col.push_back(0); exp_row.push_back(row);
        for (int s = 0; s < STEPS; s++) begin
            exp_op.push_back(1); exp_col.push_back(s * CHUNK); exp_row.push_back(row);
            for (int k = 0; k < CHUNK; k++) begin
                exp_data.push_back(int'(flash(row, s * CHUNK + k)));
                exp_step.push_back(s);
                exp_last.push_back(k == CHUNK - 1);
            end
            exp_op.push_back(1); exp_col.push_back(PAGE_WORDS + ECC_POS0 + s * EBYTES);
            exp_row.push_back(row);
        end
        strobe_cnt = 0;
        chk(!busy, "R8", "busy before go", int'(busy), 0);
        pulse_go(0, blk, pg);
        chk(busy, "R8", "busy after go", int'(busy), 1);
        if (poke) begin
            repeat (10) @(negedge clk);
            pulse_go(1, 9, 0);
        end
        while (busy) @(negedge clk);
        chk(strobe_cnt == STEPS * (CHUNK + EBYTES), "R8", "strobes when busy falls",
            strobe_cnt, STEPS * (CHUNK + EBYTES));
        chk(arm_cnt == STEPS, "R3", "ecc arm pulses", arm_cnt, STEPS);
        for (int i = 0; i < ETOT; i++) begin
            int e;
            e = int'(flash(row, PAGE_WORDS + ECC_POS0 + i));
            chk(int'(ecc_codes[i*DQ_W +: DQ_W]) == e, "R7", "stored ecc word", int'(ecc_codes[i*DQ_W +: DQ_W]), e);
        end
        while (exp_data.size() > 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(exp_op.size() == 0, "R10", "commands left unissued", exp_op.size(), 0);
        chk(!dout_valid, "R6", "stream drained", int'(dout_valid), 0);
    endtask

    task automatic run_bbm(input int blk, input bit exp_bad);
        bit seen;
        arm_cnt = 0;
        strobe_cnt = 0;
        seen = 0;
        exp_op.push_back(0); exp_col.push_back(PAGE_WORDS + MARK_POS); exp_row.push_back(blk << PG_W);
        pulse_go(1, blk, 5);
        while (busy) begin
            if (bb_done) seen = 1;
            chk(!dout_valid, "R9", "no stream in marker mode", int'(dout_valid), 0);
            @(negedge clk);
        end
        if (bb_done) seen = 1;
        chk(seen, "R9", "marker check done pulse", int'(seen), 1);
        @(negedge clk);
        chk(bb_bad == exp_bad, "R9", "bad block verdict", int'(bb_bad), int'(exp_bad));
        chk(arm_cnt == 0, "R9", "ecc arm in marker mode", arm_cnt, 0);
        chk(strobe_cnt == 1, "R9", "marker strobes", strobe_cnt, 1);
        chk(exp_op.size() == 0, "R9", "marker command issued", exp_op.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy, "R1", "busy in reset", int'(busy), 0);
        chk(nand_re_n, "R1", "re_n in reset", int'(nand_re_n), 1);
        chk(!seq_start && !ecc_arm, "R1", "start/arm in reset", int'(seq_start | ecc_arm), 0);
        chk(!dout_valid && !bb_done, "R1", "valid/done in reset", int'(dout_valid | bb_done), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        run_page(1, 2, 0, 0);
        run_page(3, 7, 1, 1);
        run_page(0, 0, 2, 0);
        run_page(15, 1, 1, 0);
        run_bbm(4, 0);
        run_bbm(5, 1);
        run_bbm(6, 1);
        run_page(2, 3, 0, 0);
        repeat (5) @(negedge clk);
        finish_up();
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        finish_up();
    end

endmodule